// File: doc/BRIEF.md
# Code memory lock-bit guard

This block keeps the three non-volatile protection bits of an on-chip code memory and turns them into a set of enables. Other logic on the chip uses these enables to block table reads that cross from external into internal code, flash programming, verify reads and execution from external memory. Software or a programmer can set a bit one at a time. Only a whole-array erase returns the bits to the unprogrammed state. A chip reset leaves them as they are.

Once the first bit is programmed, the block captures the level of the external-access pin while reset is held. It keeps that value until the next reset and compares it with the live pin on every cycle. When the two differ, or when no value has been captured since power-up or since the last erase, the block raises a mismatch flag. All outputs are registered.

Top module: `code_guard`

## Requirements
- R1: On each clock edge, every bit set in `lock_set` becomes programmed in `lock_state` (bit 0 is the first lock bit). A programmed bit stays programmed through `rst` and later edges unless an erase occurs.
- R2: An edge with `erase_req` high clears all lock bits, even when `lock_set` is non-zero in the same cycle. At power-up the lock bits are all clear.
- R3: `prot_level` gives the number of programmed bits counted upward from bit 0 that have no gap. For example, 3'b100 gives 0, 3'b011 gives 2 and 3'b111 gives 3.
- R4: At level 0, `xfetch_en`, `prog_en`, `verify_en` and `ext_exec_en` are all 1.
- R5: At level 1 or higher, `xfetch_en` and `prog_en` are 0.
- R6: At level 2 or higher, `verify_en` is 0.
- R7: At level 3, `ext_exec_en` is 0. Below level 3 it is 1.
- R8: On each edge with `rst` high and lock bit 0 already programmed, the block captures `ea_pin` and marks the capture valid. An edge with `rst` high and bit 0 clear marks the capture invalid. The capture is invalid at power-up.
- R9: `ea_mismatch` is 1 only when lock bit 0 is programmed and either the capture is invalid or the captured level differs from `ea_pin`.
- R10: An erase marks the capture invalid, and this takes priority over a reset in the same cycle.
- R11: Outputs are registered one cycle after the state and pin they reflect. An edge with `rst` high gives all enables 0, `prot_level` 0 and `ea_mismatch` 0.
- R12: Once captured, the external-access level is held against any later pin change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset, does not touch lock bits |
| lock_set | input | 3 | Per-bit program request |
| erase_req | input | 1 | Whole-array erase, clears all lock bits |
| ea_pin | input | 1 | Live external-access pin level |
| lock_state | output | 3 | Current lock bits |
| prot_level | output | 2 | Decoded protection level 0..3 |
| xfetch_en | output | 1 | Table reads from external code may read internal bytes |
| prog_en | output | 1 | Code memory programming allowed |
| verify_en | output | 1 | Verify reads allowed |
| ext_exec_en | output | 1 | Execution from external memory allowed |
| ea_mismatch | output | 1 | Captured external-access level invalid or different from pin |

## Verification
Three pairs of functions can fall in the same cycle: an erase with a bit-set request, an erase with a reset that would otherwise capture the pin, and a set with a reset. Directed cycles drive each pair at once. Random runs also let them coincide by chance. A bench model applies the stated priorities, with erase winning over set and over capture, and the next cycle's outputs are compared with that model.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;

  typedef struct packed {
    logic xfetch;
    logic prog;
    logic verify;
    logic exec;
  } guard_en_t;

  localparam guard_en_t GUARD_ALL_OFF = '{xfetch: 1'b0, prog: 1'b0, verify: 1'b0, exec: 1'b0};

endpackage

// File: rtl/guard_lock_store.sv
module guard_lock_store #(
  parameter int             LOCK_W    = 3,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '0
) (
  input  logic              clk,
  input  logic [LOCK_W-1:0] set_req,
  input  logic              erase_req,
  output logic [LOCK_W-1:0] bits
);

  // Non-volatile bits: chip reset has no effect, only erase clears.
  logic [LOCK_W-1:0] bits_q = LOCK_INIT;

  always_ff @(posedge clk) begin
    if (erase_req) bits_q <= '0;
    else           bits_q <= bits_q | set_req;
  end

  assign bits = bits_q;

endmodule

// File: rtl/guard_level_decode.sv
module guard_level_decode
  import code_guard_pkg::*;
#(
  parameter int LOCK_W     = 3,
  parameter int LVL_W      = $clog2(LOCK_W + 1),
  parameter int LVL_PROG   = 1,
  parameter int LVL_VERIFY = 2,
  parameter int LVL_EXEC   = 3
) (
  input  logic [LOCK_W-1:0] bits,
  output logic [LVL_W-1:0]  level,
  output guard_en_t         en
);

  // Count contiguous programmed bits from bit 0; a gap stops the count.
  always_comb begin
    logic run;
    run   = 1'b1;
    level = '0;
    for (int i = 0; i < LOCK_W; i++) begin
      if (run && bits[i]) level = level + 1'b1;
      else                run   = 1'b0;
    end
  end

  always_comb begin
    en.xfetch = (int'(level) < LVL_PROG);
    en.prog   = (int'(level) < LVL_PROG);
    en.verify = (int'(level) < LVL_VERIFY);
    en.exec   = (int'(level) < LVL_EXEC);
  end

endmodule

// File: rtl/guard_ext_latch.sv
module guard_ext_latch (
  input  logic clk,
  input  logic rst,
  input  logic erase_req,
  input  logic arm,
  input  logic pin,
  output logic valid,
  output logic level
);

  logic valid_q = 1'b0;
  logic level_q = 1'b0;

  always_ff @(posedge clk) begin
    if (erase_req) begin
      valid_q <= 1'b0;
    end else if (rst) begin
      valid_q <= arm;
      if (arm) level_q <= pin;
    end
  end

  assign valid = valid_q;
  assign level = level_q;

endmodule

// File: rtl/code_guard.sv
module code_guard
  import code_guard_pkg::*;
#(
  parameter int             LOCK_W    = 3,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '0,
  parameter int             LVL_W     = $clog2(LOCK_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LOCK_W-1:0] lock_set,
  input  logic              erase_req,
  input  logic              ea_pin,
  output logic [LOCK_W-1:0] lock_state,
  output logic [LVL_W-1:0]  prot_level,
  output logic              xfetch_en,
  output logic              prog_en,
  output logic              verify_en,
  output logic              ext_exec_en,
  output logic              ea_mismatch
);

  logic [LOCK_W-1:0] bits;
  logic [LVL_W-1:0]  level_c;
  guard_en_t         en_c;
  logic              ea_valid;
  logic              ea_held;
  logic              mismatch_c;

  guard_lock_store #(.LOCK_W(LOCK_W), .LOCK_INIT(LOCK_INIT)) u_store (
    .clk(clk), .set_req(lock_set), .erase_req(erase_req), .bits(bits)
  );

  guard_level_decode #(.LOCK_W(LOCK_W), .LVL_W(LVL_W)) u_decode (
    .bits(bits), .level(level_c), .en(en_c)
  );

  guard_ext_latch u_ea (
    .clk(clk), .rst(rst), .erase_req(erase_req), .arm(bits[0]),
    .pin(ea_pin), .valid(ea_valid), .level(ea_held)
  );

  assign mismatch_c = bits[0] & (~ea_valid | (ea_held ^ ea_pin));

  logic [LVL_W-1:0] level_q    = '0;
  guard_en_t        en_q       = GUARD_ALL_OFF;
  logic             mismatch_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q    <= '0;
      en_q       <= GUARD_ALL_OFF;
      mismatch_q <= 1'b0;
    end else begin
      level_q    <= level_c;
      en_q       <= en_c;
      mismatch_q <= mismatch_c;
    end
  end

  assign lock_state  = bits;
  assign prot_level  = level_q;
  assign xfetch_en   = en_q.xfetch;
  assign prog_en     = en_q.prog;
  assign verify_en   = en_q.verify;
  assign ext_exec_en = en_q.exec;
  assign ea_mismatch = mismatch_q;

endmodule

// File: rtl/code_guard_chk.sv
module code_guard_chk #(
  parameter int LOCK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [LOCK_W-1:0] lock_set,
  input logic              erase_req,
  input logic [LOCK_W-1:0] lock_state,
  input logic              xfetch_en,
  input logic              prog_en,
  input logic              verify_en,
  input logic              ext_exec_en,
  input logic              ea_mismatch
);

  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (rst)
    !erase_req |=> ((lock_state & $past(lock_state | lock_set)) == $past(lock_state | lock_set)));

  assert_erase_clears_R2: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> (lock_state == '0));

  assert_prog_off_if_verify_off_R6: assert property (@(posedge clk) disable iff (rst)
    !verify_en |-> (!prog_en && !xfetch_en));

  assert_verify_off_if_exec_off_R7: assert property (@(posedge clk) disable iff (rst)
    !ext_exec_en |-> !verify_en);

  assert_no_mismatch_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
    !lock_state[0] |=> !ea_mismatch);

  assert_reset_outputs_off_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!xfetch_en && !prog_en && !verify_en && !ext_exec_en && !ea_mismatch));

endmodule

bind code_guard code_guard_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst(rst), .lock_set(lock_set), .erase_req(erase_req),
  .lock_state(lock_state), .xfetch_en(xfetch_en), .prog_en(prog_en),
  .verify_en(verify_en), .ext_exec_en(ext_exec_en), .ea_mismatch(ea_mismatch)
);

// File: tb/code_guard_tb.sv
`timescale 1ns/1ps
module code_guard_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [2:0] lock_set = '0;
  logic       erase_req = 1'b0;
  logic       ea_pin = 1'b0;
  logic [2:0] lock_state;
  logic [1:0] prot_level;
  logic       xfetch_en, prog_en, verify_en, ext_exec_en, ea_mismatch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [2:0] m_bits  = '0;
  logic       m_valid = 1'b0;
  logic       m_ea    = 1'b0;
  logic [1:0] e_level = '0;
  logic [3:0] e_en    = '0;  // {xfetch, prog, verify, exec}
  logic       e_mis   = 1'b0;

  always #2.5 clk = ~clk;

  code_guard u_dut (
    .clk(clk), .rst(rst), .lock_set(lock_set), .erase_req(erase_req),
    .ea_pin(ea_pin), .lock_state(lock_state), .prot_level(prot_level),
    .xfetch_en(xfetch_en), .prog_en(prog_en), .verify_en(verify_en),
    .ext_exec_en(ext_exec_en), .ea_mismatch(ea_mismatch)
  );

  function automatic logic [1:0] exp_level(input logic [2:0] b);
    logic [1:0] n = '0;
    for (int i = 0; i < 3; i++) begin
      if (b[i]) n = n + 1'b1;
      else break;
    end
    return n;
  endfunction

  function automatic logic [3:0] exp_en(input logic [1:0] lv);
    return {lv < 2'd1, lv < 2'd1, lv < 2'd2, lv < 2'd3};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, predict, clock, compare.
  task automatic cyc(input logic [2:0] s, input logic er, input logic r, input logic ea);
    @(negedge clk);
    lock_set = s; erase_req = er; rst = r; ea_pin = ea;
    if (r) begin
      e_level = '0; e_en = '0; e_mis = 1'b0;
    end else begin
      e_level = exp_level(m_bits);
      e_en    = exp_en(e_level);
      e_mis   = m_bits[0] & (~m_valid | (m_ea ^ ea));
    end
    if (er) m_valid = 1'b0;
    else if (r) begin
      m_valid = m_bits[0];
      if (m_bits[0]) m_ea = ea;
    end
    if (er) m_bits = '0;
    else    m_bits = m_bits | s;
    @(posedge clk);
    #1;
    chk("R1 lock_state", lock_state, m_bits);
    chk("R3 prot_level", prot_level, e_level);
    chk("R5 xfetch_en", xfetch_en, e_en[3]);
    chk("R5 prog_en", prog_en, e_en[2]);
    chk("R6 verify_en", verify_en, e_en[1]);
    chk("R7 ext_exec_en", ext_exec_en, e_en[0]);
    chk("R9 ea_mismatch", ea_mismatch, e_mis);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1d));
    // reset state: lock bits clear, outputs off while in reset
    cyc(3'b000, 1'b0, 1'b1, 1'b0);
    chk("R2 power-up lock clear", lock_state, 0);
    cyc(3'b000, 1'b0, 1'b1, 1'b0);
    chk("R11 reset enables off", {xfetch_en, prog_en, verify_en, ext_exec_en}, 0);
    cyc(3'b000, 1'b0, 1'b0, 1'b0);
    chk("R4 level0 all enabled", {xfetch_en, prog_en, verify_en, ext_exec_en}, 4'b1111);

    // gap in lock bits: bit2 alone stays level 0
    cyc(3'b100, 1'b0, 1'b0, 1'b0);
    cyc(3'b000, 1'b0, 1'b0, 1'b0);
    chk("R3 gap level", prot_level, 0);

    // bit0 without reset: capture invalid -> mismatch
    cyc(3'b001, 1'b0, 1'b0, 1'b1);
    cyc(3'b000, 1'b0, 1'b0, 1'b1);
    chk("R9 invalid capture mismatch", ea_mismatch, 1);
    chk("R3 gap 101 level", prot_level, 1);

    // reset captures pin high, set bit1 in same cycle
    cyc(3'b010, 1'b0, 1'b1, 1'b1);
    cyc(3'b000, 1'b0, 1'b0, 1'b1);
    chk("R8 captured match", ea_mismatch, 0);
    chk("R1 set during reset", lock_state, 3'b111);
    chk("R7 level3 exec off", ext_exec_en, 0);

    // pin changes do not alter capture
    cyc(3'b000, 1'b0, 1'b0, 1'b0);
    cyc(3'b000, 1'b0, 1'b0, 1'b0);
    chk("R12 pin low vs held high", ea_mismatch, 1);
    cyc(3'b000, 1'b0, 1'b0, 1'b1);
    chk("R12 held value kept", ea_mismatch, 0);

    // erase and set in the same cycle
    cyc(3'b111, 1'b1, 1'b0, 1'b1);
    chk("R2 erase beats set", lock_state, 0);

    // erase and reset together invalidate the capture
    cyc(3'b001, 1'b0, 1'b0, 1'b1);
    cyc(3'b000, 1'b0, 1'b1, 1'b1);
    cyc(3'b000, 1'b1, 1'b1, 1'b1);
    cyc(3'b001, 1'b0, 1'b0, 1'b1);
    cyc(3'b000, 1'b0, 1'b0, 1'b1);
    chk("R10 erase invalidates capture", ea_mismatch, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] s;
      logic er, r, ea;
      s  = {($urandom % 12) == 0, ($urandom % 10) == 0, ($urandom % 8) == 0};
      er = ($urandom % 40) == 0;
      r  = ($urandom % 18) == 0;
      ea = (($urandom % 6) == 0) ? ~ea_pin : ea_pin;
      cyc(s, er, r, ea);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule